// File: doc/BRIEF.md
# Flow-Through Burst SRAM With Zero-Turnaround Late Write

This block is a synthesizable synchronous static memory that returns read data in the cycle right after the command edge. It accepts reads and writes in any order on consecutive clock edges with no idle cycles between them. Each command is registered on a rising edge. The data for a write follows on the next enabled edge, so the data bus is never driven by both sides in the same cycle. The array is small: 256 words of four 9-bit lanes by default. A memory-controller test harness, or a system that needs a single-cycle-latency scratch store, drives it with plain addresses or with four-beat bursts.

A load command supplies an address. Continue commands then step an internal two-bit beat counter in linear or interleaved order, and the address always wraps inside the aligned group of four words. A write waits in a pending register until its data arrives. A read that hits the pending word gets the new lanes merged in. A clock enable freezes the whole pipeline. An output enable gates the drivers without waiting for a clock edge. A sleep input turns the block off while the array keeps its contents.

Top module: `ftb_sram`

## Requirements
- R1: After a synchronous reset, `dq_oe` is low until a read is issued.
- R2: When a read command is registered on an enabled edge, the addressed word appears on `dq_out` and `dq_oe` goes high, with `oe_n` low, in the cycle after that edge. The output holds until the next enabled edge.
- R3: The data for a write is taken from `dq_in` on the next enabled edge after the write command. A read or a write may follow a write on the very next edge, and each returns correct data.
- R4: Write select `bw_n[i]` low writes lane i, which is bits [9i+8:9i]. With all selects high the cycle is a valid write cycle, but the stored word does not change.
- R5: `adv_ld` low loads `addr` and samples `mode`. `adv_ld` high repeats the previous command type at the next burst address. With `mode`=0 the low two address bits are the start value plus the beat count, modulo 4. With `mode`=1 they are the start value XOR the beat count. Both orders wrap inside the aligned group of four words.
- R6: A read issued on the edge that takes a pending write's data, at the same address, returns that data in the written lanes and the stored data in the other lanes.
- R7: With `cen_n` high the edge is ignored. No write takes place, no command is taken, and `dq_out`/`dq_oe` keep their values.
- R8: During the data cycle of a write, `dq_oe` is low whatever the state of `oe_n`.
- R9: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load that is not selected is a deselect and turns `dq_oe` off. A continue after a deselect keeps the output off.
- R10: `oe_n` high forces `dq_oe` low at once, with no clock edge needed.
- R11: While `zz` is high, `dq_oe` is low and every command acts as a deselect. The array keeps its contents across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low |
| addr | input | ADDR_W | Word address for a load |
| adv_ld | input | 1 | 0 loads a new address, 1 continues the burst |
| we_n | input | 1 | Write enable on a load, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| zz | input | 1 | Sleep request, active high |
| dq_in | input | DATA_W | Write data bus |
| dq_out | output | DATA_W | Read data bus |
| dq_oe | output | 1 | Output driver enable for the data bus |

## Verification
The assertions assume that no write command is pending when `zz` rises. They also assume that `rst` is high from time zero until the first edges, so that no property sees an unreset pipeline. The stimulus keeps `zz` low during all random traffic and raises it only in a directed sequence that consists of deselects and reads. Random traffic mixes stalls, continues, writes with any lane mask, chip-enable patterns and burst modes. Directed cases cover the exact burst orders, the same-address bypass, the no-lane write and the asynchronous output gating.

// File: rtl/ftb_sram_pkg.sv
package ftb_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ftb_sram_burst.sv
module ftb_sram_burst #(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_ilv,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              ilv_q;
  logic [BEAT_W-1:0] lo;

  always_comb begin
    lo = ilv_q ? (base_q[BEAT_W-1:0] ^ cnt_q) : (base_q[BEAT_W-1:0] + cnt_q);
    cur_addr = load ? ld_addr : {base_q[ADDR_W-1:BEAT_W], lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (step) begin
      if (load) begin
        base_q <= ld_addr;
        ilv_q  <= ld_ilv;
        cnt_q  <= BEAT_W'(1);
      end else begin
        cnt_q <= cnt_q + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ftb_sram_array.sv
module ftb_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      if (rd_en) rd_data[g*LANE_W +: LANE_W] <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/ftb_sram.sv
module ftb_sram
  import ftb_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              oe_n,
  input  logic              mode,
  input  logic              zz,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int BEAT_W = 2;

  logic              en;
  logic              chip_sel;
  op_e               prev_op, cur_op;
  logic [ADDR_W-1:0] acc_addr;
  logic              wp_vld;
  logic [ADDR_W-1:0] wp_addr;
  logic [LANES-1:0]  wp_be;
  logic              wr_en, rd_en;
  logic              rd_vld;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] byp_data;
  logic [LANES-1:0]  byp_mask;

  assign en       = ~cen_n;
  assign chip_sel = ~ce1_n & ce2 & ~ce3_n & ~zz;

  // Command decode: a load picks a fresh op, a continue repeats the last one
  always_comb begin
    if (!adv_ld) cur_op = chip_sel ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
    else         cur_op = zz ? OP_IDLE : prev_op;
  end

  ftb_sram_burst #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) burst_i (
    .clk      (clk),
    .rst      (rst),
    .step     (en),
    .load     (~adv_ld),
    .ld_addr  (addr),
    .ld_ilv   (mode),
    .cur_addr (acc_addr)
  );

  // Late write: the pending command commits with the data present one enabled edge later
  assign wr_en = en & wp_vld & ~rst;
  assign rd_en = en & (cur_op == OP_READ);

  ftb_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_addr (acc_addr),
    .rd_data (mem_q),
    .wr_en   (wr_en),
    .wr_addr (wp_addr),
    .wr_be   (wp_be),
    .wr_data (dq_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_op <= OP_IDLE;
      wp_vld  <= 1'b0;
      wp_addr <= '0;
      wp_be   <= '0;
      rd_vld  <= 1'b0;
    end else if (en) begin
      prev_op <= cur_op;
      wp_vld  <= (cur_op == OP_WRITE);
      wp_addr <= acc_addr;
      wp_be   <= ~bw_n;
      rd_vld  <= (cur_op == OP_READ);
    end
  end

  // Coherency capture: lanes committed on the same edge bypass the array read
  always_ff @(posedge clk) begin
    if (rd_en) begin
      byp_data <= dq_in;
      byp_mask <= (wp_vld && (wp_addr == acc_addr)) ? wp_be : '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_out[g*LANE_W +: LANE_W] = byp_mask[g] ? byp_data[g*LANE_W +: LANE_W]
                                                    : mem_q[g*LANE_W +: LANE_W];
  end

  assign dq_oe = rd_vld & ~oe_n & ~zz;
endmodule

// File: rtl/ftb_sram_chk.sv
module ftb_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              adv_ld,
  input logic              we_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              oe_n,
  input logic              zz,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              wp_vld,
  input logic              rd_vld
);
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ($stable(dq_out) && $stable(rd_vld)));

  a_r8_wdata_off: assert property (@(posedge clk) disable iff (rst)
    wp_vld |-> !dq_oe);

  a_r10_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  a_r11_sleep_off: assert property (@(posedge clk) disable iff (rst)
    zz |-> !dq_oe);

  a_r9_desel_off: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld && (ce1_n || !ce2 || ce3_n)) |=> !dq_oe);

  a_r3_write_pend: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld && !ce1_n && ce2 && !ce3_n && !zz && !we_n) |=> (wp_vld && !rd_vld));
endmodule

bind ftb_sram ftb_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .cen_n  (cen_n),
  .adv_ld (adv_ld),
  .we_n   (we_n),
  .ce1_n  (ce1_n),
  .ce2    (ce2),
  .ce3_n  (ce3_n),
  .oe_n   (oe_n),
  .zz     (zz),
  .dq_out (dq_out),
  .dq_oe  (dq_oe),
  .wp_vld (wp_vld),
  .rd_vld (rd_vld)
);

// File: tb/ftb_sram_tb_top.sv
`timescale 1ns/1ps
module ftb_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cen_n = 1'b0, adv_ld = 1'b0, we_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        oe_n = 1'b0, mode = 1'b0, zz = 1'b0;
  logic [7:0]  addr = '0;
  logic [35:0] dq_in = '0;
  logic [35:0] dq_out;
  logic        dq_oe;

  int n_chk = 0, n_err = 0;

  // bench model state
  logic [35:0] exp_mem [256];
  int          m_op = 0;
  logic [7:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  logic        m_ilv = 1'b0;
  logic        m_wpv = 1'b0;
  logic [7:0]  m_wpa = '0;
  logic [3:0]  m_wpbe = '0;
  logic        m_rdv = 1'b0;
  logic [35:0] m_rd = '0;

  always #10 clk = ~clk;

  ftb_sram dut_i (
    .clk(clk), .rst(rst), .cen_n(cen_n), .addr(addr), .adv_ld(adv_ld),
    .we_n(we_n), .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .oe_n(oe_n), .mode(mode), .zz(zz), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [35:0] pat(input logic [7:0] a);
    return {a[0], a, a[1], ~a, a[2], a ^ 8'hA5, a[3], a + 8'd7};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cen, input bit adv, input bit wen, input bit [3:0] bw,
                      input bit sel, input bit [7:0] a, input bit [35:0] d,
                      input bit md, input bit oe, input bit z, input string tag);
    int op;
    logic [7:0] ac;
    logic [1:0] lo;
    bit exp_oe;
    @(negedge clk);
    cen_n = cen; adv_ld = adv; we_n = wen; bw_n = bw; addr = a; dq_in = d;
    mode = md; oe_n = oe; zz = z;
    if (sel) begin ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; end
    else begin
      case ($urandom % 3)
        0: begin ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; end
        1: begin ce1_n = 1'b0; ce2 = 1'b0; ce3_n = 1'b0; end
        default: begin ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b1; end
      endcase
    end
    if (!cen) begin
      if (m_wpv)
        for (int l = 0; l < 4; l++)
          if (m_wpbe[l]) exp_mem[m_wpa][l*9 +: 9] = d[l*9 +: 9];
      if (!adv) op = (sel && !z) ? (wen ? 1 : 2) : 0;
      else      op = z ? 0 : m_op;
      if (!adv) begin
        ac = a; m_base = a; m_cnt = 2'd1; m_ilv = md;
      end else begin
        lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        ac = {m_base[7:2], lo};
        m_cnt = m_cnt + 2'd1;
      end
      m_rdv = (op == 1);
      if (op == 1) m_rd = exp_mem[ac];
      m_wpv = (op == 2); m_wpa = ac; m_wpbe = ~bw; m_op = op;
    end
    @(posedge clk);
    #5;
    exp_oe = m_rdv && !oe && !z;
    chk(dq_oe == exp_oe, {tag, " oe"}, 36'(dq_oe), 36'(exp_oe));
    if (exp_oe) chk(dq_out == m_rd, {tag, " data"}, dq_out, m_rd);
  endtask

  task automatic chkv(input string tag, input logic [35:0] exp);
    chk(dq_oe === 1'b1 && dq_out === exp, tag, dq_out, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [35:0] dv;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 chk(dq_oe == 1'b0, "R1 reset output off", 36'(dq_oe), 36'd0);

    // preload every word with linear write bursts (R3, R5)
    for (int j = 0; j < 256; j++)
      step(0, (j % 4) != 0, 0, 4'h0, 1, 8'(j), (j == 0) ? 36'd0 : pat(8'(j - 1)), 0, 0, 0, "R3 preload");
    step(0, 0, 1, 4'hF, 0, 8'h00, pat(8'hFF), 0, 0, 0, "R9 flush");

    // R5 linear burst from 0x21
    step(0, 0, 1, 4'hF, 1, 8'h21, '0, 0, 0, 0, "R2 load");  chkv("R5 lin b0", pat(8'h21));
    step(0, 1, 1, 4'hF, 1, 8'h00, '0, 1, 0, 0, "R5 lin");   chkv("R5 lin b1", pat(8'h22));
    step(0, 1, 1, 4'hF, 1, 8'h00, '0, 1, 0, 0, "R5 lin");   chkv("R5 lin b2", pat(8'h23));
    step(0, 1, 1, 4'hF, 1, 8'h00, '0, 1, 0, 0, "R5 lin");   chkv("R5 lin b3 wrap", pat(8'h20));
    // R5 interleaved burst from 0x21
    step(0, 0, 1, 4'hF, 1, 8'h21, '0, 1, 0, 0, "R5 ilv");  chkv("R5 ilv b0", pat(8'h21));
    step(0, 1, 1, 4'hF, 1, 8'h00, '0, 0, 0, 0, "R5 ilv");  chkv("R5 ilv b1", pat(8'h20));
    step(0, 1, 1, 4'hF, 1, 8'h00, '0, 0, 0, 0, "R5 ilv");  chkv("R5 ilv b2", pat(8'h23));
    step(0, 1, 1, 4'hF, 1, 8'h00, '0, 0, 0, 0, "R5 ilv");  chkv("R5 ilv b3", pat(8'h22));

    // R7 stall: read, then a stalled write attempt must change nothing
    step(0, 0, 1, 4'hF, 1, 8'h30, '0, 0, 0, 0, "R2 read");
    step(1, 0, 0, 4'h0, 1, 8'h31, 36'hF_FFFF_FFFF, 0, 0, 0, "R7 stall");
    chkv("R7 stall holds output", pat(8'h30));
    step(1, 0, 0, 4'h0, 1, 8'h31, 36'hF_FFFF_FFFF, 0, 0, 0, "R7 stall");
    step(0, 0, 1, 4'hF, 1, 8'h31, 36'hF_FFFF_FFFF, 0, 0, 0, "R7 read after stall");
    chkv("R7 no write under stall", pat(8'h31));

    // R8 and R6: write lanes 0 and 2, read same word on the data edge
    step(0, 0, 0, 4'b1010, 1, 8'h40, '0, 0, 0, 0, "R8 write cmd");
    dv = 36'h1_2345_6789;
    step(0, 0, 1, 4'hF, 1, 8'h40, dv, 0, 0, 0, "R6 bypass read");
    chkv("R6 merged lanes", {pat(8'h40)[35:27], dv[26:18], pat(8'h40)[17:9], dv[8:0]});

    // R4 no-lane write leaves word intact
    step(0, 0, 0, 4'hF, 1, 8'h50, '0, 0, 0, 0, "R4 empty write");
    step(0, 0, 1, 4'hF, 1, 8'h50, 36'h0_DEAD_BEEF, 0, 0, 0, "R4 read");
    chkv("R4 no lane written", pat(8'h50));

    // R3 back-to-back writes then reads
    step(0, 0, 0, 4'h0, 1, 8'h60, '0, 0, 0, 0, "R3 wr a");
    step(0, 0, 0, 4'h0, 1, 8'h61, 36'h0_AAAA_0001, 0, 0, 0, "R3 wr b");
    step(0, 0, 1, 4'hF, 1, 8'h60, 36'h0_BBBB_0002, 0, 0, 0, "R3 rd a");
    chkv("R3 first write", 36'h0_AAAA_0001);
    step(0, 0, 1, 4'hF, 1, 8'h61, '0, 0, 0, 0, "R3 rd b");
    chkv("R3 second write", 36'h0_BBBB_0002);

    // R9 deselect then continue-deselect
    step(0, 0, 1, 4'hF, 0, 8'h10, '0, 0, 0, 0, "R9 deselect");
    chk(dq_oe == 1'b0, "R9 deselect off", 36'(dq_oe), 36'd0);
    step(0, 1, 1, 4'hF, 1, 8'h10, '0, 0, 0, 0, "R9 continue deselect");
    chk(dq_oe == 1'b0, "R9 continue stays off", 36'(dq_oe), 36'd0);

    // R10 asynchronous output gating
    step(0, 0, 1, 4'hF, 1, 8'h22, '0, 0, 0, 0, "R10 read");
    oe_n = 1'b1; #1 chk(dq_oe == 1'b0, "R10 oe_n high", 36'(dq_oe), 36'd0);
    oe_n = 1'b0; #1 chk(dq_oe == 1'b1, "R10 oe_n low", 36'(dq_oe), 36'd1);

    // R11 sleep with deselects and reads only
    step(0, 0, 1, 4'hF, 0, 8'h00, '0, 0, 0, 1, "R11 enter");
    step(0, 0, 1, 4'hF, 1, 8'h23, '0, 0, 0, 1, "R11 read asleep");
    chk(dq_oe == 1'b0, "R11 off while asleep", 36'(dq_oe), 36'd0);
    step(0, 0, 1, 4'hF, 0, 8'h00, '0, 0, 0, 0, "R11 wake");
    step(0, 0, 1, 4'hF, 1, 8'h23, '0, 0, 0, 0, "R11 read");
    chkv("R11 contents kept", pat(8'h23));

    // constrained random traffic: R2 R3 R4 R5 R6 R7 R9 R10
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 10) == 0, ($urandom % 5) < 2, $urandom % 2, 4'($urandom),
           ($urandom % 8) != 0, 8'($urandom), {4'($urandom), 32'($urandom)},
           $urandom % 2, ($urandom % 10) == 0, 0, "R2 R3 R4 R5 R6 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule